// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This controller collects thirty interrupt request lines and hands the processor one winning request at a time. The lines are one non-maskable input, four external request inputs and twenty-five requests from on-chip peripherals: one watchdog, fifteen timer-unit, eight serial-port and one converter request. Each of the twenty-nine maskable sources has a bit in one of two software-written priority registers. The bit places the source at the high level or the low level. The non-maskable input sits above both levels.

The processor sees a registered vector number and a valid flag. These outputs hold steady until the processor returns a one-cycle acknowledge. Two mask inputs narrow which sources can be accepted: one blocks every maskable source, and the other blocks only the low level. After reset, nothing is accepted, the non-maskable input included, until the processor reports that its first instruction has completed. That instruction is normally the one that sets up the stack.

Top module: `prio_intc`

## Requirements
- R1: After reset, `irq_valid` is 0, both priority registers are zero so that every maskable source is at the low level, and no non-maskable request is pending.
- R2: From reset until a cycle with `first_insn_done` high, no request is accepted, the non-maskable one included. A rising edge on `nmi_in` seen during that window is discarded.
- R3: A rising edge on `nmi_in` becomes a pending request. That request wins over all maskable sources and is accepted whatever the state of `mask_all` and `mask_low`.
- R4: The pending non-maskable request is cleared when the processor acknowledges vector 7. Holding `nmi_in` high afterwards does not produce a second interrupt.
- R5: A cycle with `pri_we` high and `pri_sel` 0 loads the priority bits of sources 0..15 from `pri_wdata[15:0]`. With `pri_sel` 1 it loads sources 16..28 from `pri_wdata[12:0]`. A bit value of 1 means high level.
- R6: A pending high-level source beats any pending low-level source, whatever their indices.
- R7: Among sources at the same level, the lowest source index wins. Sources 0..3 are `irq_ext[0..3]` and sources 4..28 are `irq_int[0..24]`. The maskable inputs are level requests.
- R8: The non-maskable request is reported as vector 7. Maskable source i is reported as vector 12+i.
- R9: While `mask_all` is 1, no maskable source is accepted.
- R10: While `mask_low` is 1, low-level sources are not accepted and high-level sources still are.
- R11: Once `irq_valid` is 1, it and `irq_vector` stay unchanged until a cycle with `ack` high, even if the requests change. In the cycle after that acknowledge, `irq_valid` is 0.
- R12: A level request sampled at a clock edge while the output is idle raises `irq_valid` after that same edge. A rising edge of `nmi_in` raises `irq_valid` one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_in | input | 1 | Non-maskable request, edge sensitive |
| irq_ext | input | 4 | External level requests, sources 0..3 |
| irq_int | input | 25 | Peripheral level requests, sources 4..28 |
| first_insn_done | input | 1 | Processor has finished its first instruction |
| mask_all | input | 1 | Blocks all maskable sources |
| mask_low | input | 1 | Blocks low-level sources only |
| ack | input | 1 | Acknowledge of the presented vector |
| pri_we | input | 1 | Priority register write strobe |
| pri_sel | input | 1 | 0 selects register A (sources 0..15), 1 selects register B (16..28) |
| pri_wdata | input | 16 | Priority register write data |
| irq_valid | output | 1 | A request is being presented |
| irq_vector | output | 6 | Vector number of the presented request |

## Verification
Several properties are checked on every cycle. The outputs stay quiet while the post-reset block is active. They stay frozen until acknowledge, and the valid flag drops after an acknowledge. The vector always lies in the legal range. A pending non-maskable request is always the next thing presented, and nothing maskable is loaded under `mask_all`. The bench scenarios cover the rest: which source wins under each priority-register setting and mask combination, the index tie-break, how the register halves map onto sources, the discarding of edges during the boot window, the single interrupt from a held non-maskable line, and the exact cycle in which each kind of request appears.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;

    localparam int VEC_W = 6;

    typedef struct packed {
        logic             valid;
        logic             is_nmi;
        logic [VEC_W-1:0] vector;
    } grant_t;

    function automatic logic [VEC_W-1:0] src_vector(input logic [VEC_W-1:0] base,
                                                    input int unsigned idx);
        return base + VEC_W'(idx);
    endfunction

endpackage

// File: rtl/prio_intc_nmi_edge.sv
module prio_intc_nmi_edge (
    input  logic clk,
    input  logic rst,
    input  logic nmi_in,
    input  logic enable,
    input  logic clr,
    output logic pend
);
    logic nmi_q;
    logic rise;

    assign rise = nmi_in & ~nmi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_q <= 1'b0;
            pend  <= 1'b0;
        end else begin
            nmi_q <= nmi_in;
            if (rise && enable)
                pend <= 1'b1;
            else if (clr)
                pend <= 1'b0;
        end
    end
endmodule

// File: rtl/prio_intc_pri_regs.sv
module prio_intc_pri_regs #(
    parameter int N_SRC = 29,
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic             sel,
    input  logic [REG_W-1:0] wdata,
    output logic [N_SRC-1:0] high
);
    for (genvar i = 0; i < N_SRC; i++) begin : g_bit
        if (i < REG_W) begin : g_lo
            always_ff @(posedge clk) begin
                if (rst)
                    high[i] <= 1'b0;
                else if (we && !sel)
                    high[i] <= wdata[i];
            end
        end else begin : g_hi
            always_ff @(posedge clk) begin
                if (rst)
                    high[i] <= 1'b0;
                else if (we && sel)
                    high[i] <= wdata[i-REG_W];
            end
        end
    end
endmodule

// File: rtl/prio_intc_picker.sv
module prio_intc_picker #(
    parameter int N_SRC = 29,
    parameter int IDX_W = 5
) (
    input  logic [N_SRC-1:0] req,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/prio_intc_arbiter.sv
module prio_intc_arbiter
    import prio_intc_pkg::*;
#(
    parameter int               N_SRC    = 29,
    parameter logic [VEC_W-1:0] NMI_VEC  = 6'd7,
    parameter logic [VEC_W-1:0] VEC_BASE = 6'd12
) (
    input  logic [N_SRC-1:0] req,
    input  logic [N_SRC-1:0] high,
    input  logic             nmi_pend,
    input  logic             mask_all,
    input  logic             mask_low,
    output grant_t           grant
);
    localparam int IDX_W = $clog2(N_SRC);

    logic [N_SRC-1:0] lvl_req [2];
    logic             lvl_hit [2];
    logic [IDX_W-1:0] lvl_idx [2];

    // level 1 = high, level 0 = low
    assign lvl_req[1] = mask_all ? '0 : (req & high);
    assign lvl_req[0] = (mask_all || mask_low) ? '0 : (req & ~high);

    for (genvar l = 0; l < 2; l++) begin : g_lvl
        prio_intc_picker #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_pick (
            .req (lvl_req[l]),
            .hit (lvl_hit[l]),
            .idx (lvl_idx[l])
        );
    end

    always_comb begin
        grant = '0;
        if (nmi_pend) begin
            grant.valid  = 1'b1;
            grant.is_nmi = 1'b1;
            grant.vector = NMI_VEC;
        end else if (lvl_hit[1]) begin
            grant.valid  = 1'b1;
            grant.vector = src_vector(VEC_BASE, int'(lvl_idx[1]));
        end else if (lvl_hit[0]) begin
            grant.valid  = 1'b1;
            grant.vector = src_vector(VEC_BASE, int'(lvl_idx[0]));
        end
    end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import prio_intc_pkg::*;
#(
    parameter int               N_EXT    = 4,
    parameter int               N_INT    = 25,
    parameter int               REG_W    = 16,
    parameter logic [VEC_W-1:0] NMI_VEC  = 6'd7,
    parameter logic [VEC_W-1:0] VEC_BASE = 6'd12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             nmi_in,
    input  logic [N_EXT-1:0] irq_ext,
    input  logic [N_INT-1:0] irq_int,
    input  logic             first_insn_done,
    input  logic             mask_all,
    input  logic             mask_low,
    input  logic             ack,
    input  logic             pri_we,
    input  logic             pri_sel,
    input  logic [REG_W-1:0] pri_wdata,
    output logic             irq_valid,
    output logic [VEC_W-1:0] irq_vector
);
    localparam int N_SRC = N_EXT + N_INT;

    logic             boot_blk;
    logic             nmi_pend;
    logic             out_nmi;
    logic             nmi_clr;
    logic [N_SRC-1:0] high;
    grant_t           grant;

    assign nmi_clr = irq_valid & ack & out_nmi;

    prio_intc_nmi_edge u_nmi (
        .clk    (clk),
        .rst    (rst),
        .nmi_in (nmi_in),
        .enable (~boot_blk),
        .clr    (nmi_clr),
        .pend   (nmi_pend)
    );

    prio_intc_pri_regs #(.N_SRC(N_SRC), .REG_W(REG_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (pri_we),
        .sel   (pri_sel),
        .wdata (pri_wdata),
        .high  (high)
    );

    prio_intc_arbiter #(.N_SRC(N_SRC), .NMI_VEC(NMI_VEC), .VEC_BASE(VEC_BASE)) u_arb (
        .req      ({irq_int, irq_ext}),
        .high     (high),
        .nmi_pend (nmi_pend),
        .mask_all (mask_all),
        .mask_low (mask_low),
        .grant    (grant)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            boot_blk   <= 1'b1;
            irq_valid  <= 1'b0;
            irq_vector <= '0;
            out_nmi    <= 1'b0;
        end else begin
            if (first_insn_done)
                boot_blk <= 1'b0;
            if (irq_valid) begin
                if (ack)
                    irq_valid <= 1'b0;
            end else if (!boot_blk && grant.valid) begin
                irq_valid  <= 1'b1;
                irq_vector <= grant.vector;
                out_nmi    <= grant.is_nmi;
            end
        end
    end
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk
    import prio_intc_pkg::*;
#(
    parameter int               N_SRC    = 29,
    parameter logic [VEC_W-1:0] NMI_VEC  = 6'd7,
    parameter logic [VEC_W-1:0] VEC_BASE = 6'd12
) (
    input logic             clk,
    input logic             rst,
    input logic             boot_blk,
    input logic             nmi_pend,
    input logic             mask_all,
    input logic             ack,
    input logic             irq_valid,
    input logic [VEC_W-1:0] irq_vector
);
    p_boot_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        boot_blk |-> !irq_valid);

    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (irq_valid && !ack) |=> (irq_valid && $stable(irq_vector)));

    p_gap_r11: assert property (@(posedge clk) disable iff (rst)
        (irq_valid && ack) |=> !irq_valid);

    p_vec_range_r8: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> (irq_vector == NMI_VEC ||
                       (irq_vector >= VEC_BASE && irq_vector < VEC_BASE + VEC_W'(N_SRC))));

    p_nmi_next_r3: assert property (@(posedge clk) disable iff (rst)
        (!irq_valid && nmi_pend && !boot_blk) |=> (irq_valid && irq_vector == NMI_VEC));

    p_mask_all_r9: assert property (@(posedge clk) disable iff (rst)
        (irq_valid && !$past(irq_valid) && $past(mask_all)) |-> irq_vector == NMI_VEC);
endmodule

bind prio_intc prio_intc_chk #(
    .N_SRC(N_SRC), .NMI_VEC(NMI_VEC), .VEC_BASE(VEC_BASE)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .boot_blk   (boot_blk),
    .nmi_pend   (nmi_pend),
    .mask_all   (mask_all),
    .ack        (ack),
    .irq_valid  (irq_valid),
    .irq_vector (irq_vector)
);

// File: tb/tb_prio_intc.sv
module tb_prio_intc;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        nmi_in = 1'b0;
    logic [3:0]  irq_ext = '0;
    logic [24:0] irq_int = '0;
    logic        first_insn_done = 1'b0;
    logic        mask_all = 1'b0;
    logic        mask_low = 1'b0;
    logic        ack = 1'b0;
    logic        pri_we = 1'b0;
    logic        pri_sel = 1'b0;
    logic [15:0] pri_wdata = '0;
    logic        irq_valid;
    logic [5:0]  irq_vector;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    prio_intc dut (.*);

    typedef struct packed {
        logic [3:0]  ext;
        logic [24:0] intr;
        logic [15:0] pa;
        logic [15:0] pb;
        logic        ma;
        logic        ml;
        logic        ev;
        logic [5:0]  evec;
    } row_t;

    localparam int NROW = 9;
    localparam row_t TBL [NROW] = '{
        '{4'b0001, 25'h0,       16'h0,    16'h0,    1'b0, 1'b0, 1'b1, 6'd12}, // R7 R8 src0
        '{4'b0000, 25'h1000000, 16'h0,    16'h0,    1'b0, 1'b0, 1'b1, 6'd40}, // R8 src28
        '{4'b0100, 25'h1,       16'h0,    16'h0,    1'b0, 1'b0, 1'b1, 6'd14}, // R7 src2 over src4
        '{4'b0100, 25'h1,       16'h0010, 16'h0,    1'b0, 1'b0, 1'b1, 6'd16}, // R6 high src4
        '{4'b0001, 25'h100000,  16'h0,    16'h0100, 1'b0, 1'b0, 1'b1, 6'd36}, // R5 reg B src24
        '{4'b0011, 25'h0,       16'h0,    16'h0,    1'b1, 1'b0, 1'b0, 6'd0},  // R9
        '{4'b0001, 25'h8,       16'h0080, 16'h0,    1'b0, 1'b1, 1'b1, 6'd19}, // R10 high src7
        '{4'b0001, 25'h0,       16'h0,    16'h0,    1'b0, 1'b1, 1'b0, 6'd0},  // R10 low blocked
        '{4'b0000, 25'hC00,     16'hC000, 16'h0,    1'b0, 1'b0, 1'b1, 6'd26}  // R7 high tie src14
    };

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(logic sel, logic [15:0] d);
        pri_we = 1'b1; pri_sel = sel; pri_wdata = d;
        step(1);
        pri_we = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step(2);
        rst = 1'b0;
    endtask

    task automatic release_boot();
        first_insn_done = 1'b1;
        step(1);
        first_insn_done = 1'b0;
    endtask

    task automatic ack_clear();
        ack = 1'b1; irq_ext = '0; irq_int = '0;
        step(1);
        ack = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            finish_run();
        end
    end

    initial begin
        step(1);
        // R1: priority bit set before reset must be cleared by it
        rst = 1'b0;
        step(1);
        wr(1'b0, 16'h0010);
        do_reset();
        chk("R1 valid after reset", int'(irq_valid), 0);
        release_boot();
        irq_ext = 4'b0100; irq_int = 25'h1;
        step(3);
        chk("R1 priority cleared, src2 wins", int'(irq_vector), 14);
        ack_clear();
        step(1);
        chk("R11 idle after ack", int'(irq_valid), 0);

        // table walk
        for (int r = 0; r < NROW; r++) begin
            wr(1'b0, TBL[r].pa);
            wr(1'b1, TBL[r].pb);
            irq_ext = TBL[r].ext; irq_int = TBL[r].intr;
            mask_all = TBL[r].ma; mask_low = TBL[r].ml;
            step(3);
            chk($sformatf("R5-table row %0d valid (R6 R7 R9 R10)", r), int'(irq_valid), int'(TBL[r].ev));
            if (TBL[r].ev)
                chk($sformatf("R8 table row %0d vector", r), int'(irq_vector), int'(TBL[r].evec));
            mask_all = 1'b0; mask_low = 1'b0;
            if (irq_valid) ack_clear();
            else begin irq_ext = '0; irq_int = '0; step(1); end
            step(1);
            chk($sformatf("R11 row %0d idle", r), int'(irq_valid), 0);
        end

        // R2: boot block discards requests and NMI edge
        do_reset();
        irq_ext = 4'b0001; nmi_in = 1'b1;
        step(5);
        chk("R2 blocked during boot", int'(irq_valid), 0);
        nmi_in = 1'b0;
        step(1);
        release_boot();
        step(1);
        chk("R2 level request accepted after release", int'(irq_vector), 12);
        ack_clear();
        step(3);
        chk("R2 boot-window NMI edge discarded", int'(irq_valid), 0);

        // R12 timing and R3 NMI beating a high source
        wr(1'b0, 16'h0002);
        irq_ext = 4'b0010;
        step(1);
        chk("R12 level request one edge", int'(irq_valid), 1);
        ack_clear();
        step(1);
        nmi_in = 1'b1;
        step(1);
        chk("R12 NMI not yet after one edge", int'(irq_valid), 0);
        irq_ext = 4'b0010;
        step(1);
        chk("R12 NMI after two edges", int'(irq_valid), 1);
        chk("R3 NMI beats high source", int'(irq_vector), 7);
        // R4: ack clears; held NMI gives no repeat
        ack = 1'b1;
        step(1);
        ack = 1'b0;
        step(2);
        chk("R4 held NMI no repeat", int'(irq_vector), 13);
        ack_clear();
        nmi_in = 1'b0;
        step(2);
        chk("R4 idle after NMI served", int'(irq_valid), 0);

        // R3: NMI ignores masks
        mask_all = 1'b1; mask_low = 1'b1; irq_ext = 4'b0011;
        step(2);
        chk("R9 masked request ignored", int'(irq_valid), 0);
        nmi_in = 1'b1;
        step(3);
        chk("R3 NMI accepted under masks", int'(irq_vector), 7);
        ack_clear();
        mask_all = 1'b0; mask_low = 1'b0; nmi_in = 1'b0;
        step(2);

        // R11: hold while requests change
        irq_ext = 4'b1000;
        step(2);
        irq_ext = 4'b0000; irq_int = 25'h1;
        wr(1'b0, 16'h0010);
        step(3);
        chk("R11 valid held", int'(irq_valid), 1);
        chk("R11 vector held", int'(irq_vector), 15);
        ack = 1'b1;
        step(1);
        ack = 1'b0;
        chk("R11 gap after ack", int'(irq_valid), 0);
        step(1);
        chk("R7 remaining source next", int'(irq_vector), 16);
        ack_clear();
        step(2);

        done = 1'b1;
        finish_run();
    end
endmodule